// File: doc/BRIEF.md
# Volley-Based Ball Speed Pulse Generator

This block sets the horizontal speed of the ball in a raster ball game. It counts paddle hits from both players in a saturating volley counter. At each frame reset it turns that count into a number of scan lines, one, two or three. It then holds a move enable high for exactly that many scan lines. Each scan line with the enable high moves the ball one pixel, so long rallies make the ball faster.

The surrounding game logic supplies four single-cycle strobes in the pixel clock domain: a hit, a speed clear, a frame reset and a start-of-line. It takes back the move enable and the current volley count. The speed range is captured at the frame reset, so a hit in the middle of a frame first changes the speed in the next frame.

Top module: `volley_speed_gen`

## Requirements
- R1: A hit strobe with no speed clear raises the volley count by one, and the new value shows on `volleyCount` in the cycle after the strobe.
- R2: The volley count saturates at 12. A hit while the count is 12 leaves it at 12.
- R3: A speed clear sets the volley count to 0 in the next cycle, and it takes priority over a hit in the same cycle.
- R4: The line count is selected from the volley count at frame reset: 0 to 3 give one move line, 4 to 11 give two, and 12 to 15 give three.
- R5: In the cycle after a frame reset, `moveEn` is high.
- R6: Each line strobe after a frame reset uses up one move line. `moveEn` falls in the cycle after the strobe that uses up the last selected line.
- R7: Once `moveEn` has fallen, it stays low through any number of line strobes until the next frame reset.
- R8: When a frame reset and a line strobe arrive in the same cycle, the frame reset wins. The line count restarts, and no line is used up.
- R9: A hit during a frame does not change that frame's line count. It takes effect from the next frame reset. A hit in the same cycle as a frame reset also waits for the next frame.
- R10: After the asynchronous active-low reset, the volley count is 0 and `moveEn` is low until the first frame reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hitStrobe | input | 1 | One-cycle pulse when either paddle hits the ball |
| speedClear | input | 1 | One-cycle pulse that clears the volley count |
| frameReset | input | 1 | One-cycle pulse for the vertical reset at the start of a frame |
| lineStrobe | input | 1 | One-cycle pulse at the start of each scan line |
| moveEn | output | 1 | High for the selected number of scan lines after each frame reset |
| volleyCount | output | 4 | Current saturating volley count |

## Verification
The in-RTL assertions check on every cycle that the count never passes 12. They also check that a hit adds exactly one below saturation, that a clear always reaches zero, that the enable rises after each frame reset, and that a low enable stays low without a frame reset. The number of lines produced for each count range, the priority of a frame reset over a line strobe, and the delay of a mid-frame hit to the next frame can only be shown by the bench. Its scenarios count the line strobes that pass while the enable is high.

// File: rtl/volley_pkg.sv
package volley_pkg;
  // Control strobes from the control module to the datapath.
  typedef struct packed {
    logic cntClr;   // clear the volley count
    logic cntInc;   // request one increment (datapath saturates)
    logic seqLoad;  // frame start: capture range, restart line count
    logic seqStep;  // scan line boundary: use up one move line
  } ctrlStrobes_t;
endpackage

// File: rtl/volley_ctrl.sv
module volley_ctrl
  import volley_pkg::*;
(
  input  logic         hitStrobe,
  input  logic         speedClear,
  input  logic         frameReset,
  input  logic         lineStrobe,
  output ctrlStrobes_t strobes
);
  // The priorities are resolved here, so the datapath sees one action per part.
  always_comb begin
    strobes.cntClr  = speedClear;
    strobes.cntInc  = hitStrobe & ~speedClear;   // clear wins (R3)
    strobes.seqLoad = frameReset;
    strobes.seqStep = lineStrobe & ~frameReset;  // frame reset wins (R8)
  end
endmodule

// File: rtl/volley_dp.sv
module volley_dp
  import volley_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SAT_COUNT = 12,
  parameter int MID_START = 4,
  parameter int TOP_START = 12,
  parameter int LINE_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobes,
  output logic             moveEn,
  output logic [CNT_W-1:0] volleyCount
);
  localparam logic [CNT_W-1:0]  SAT_V  = CNT_W'(SAT_COUNT);
  localparam logic [CNT_W-1:0]  MID_V  = CNT_W'(MID_START);
  localparam logic [CNT_W-1:0]  TOP_V  = CNT_W'(TOP_START);
  localparam logic [LINE_W-1:0] ONE_L  = LINE_W'(1);
  localparam logic [LINE_W-1:0] TWO_L  = LINE_W'(2);
  localparam logic [LINE_W-1:0] THR_L  = LINE_W'(3);

  logic [CNT_W-1:0]  volleyCnt;
  logic [LINE_W-1:0] lineTarget;
  logic [LINE_W-1:0] linesUsed;
  logic [LINE_W-1:0] rangeLines;

  // Saturating volley counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                volleyCnt <= '0;
    else if (strobes.cntClr)                   volleyCnt <= '0;
    else if (strobes.cntInc && volleyCnt < SAT_V) volleyCnt <= volleyCnt + CNT_W'(1);
  end

  // Decode the count into a number of move lines
  always_comb begin
    if (volleyCnt >= TOP_V)      rangeLines = THR_L;
    else if (volleyCnt >= MID_V) rangeLines = TWO_L;
    else                         rangeLines = ONE_L;
  end

  // Line sequencer: the target is captured once per frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineTarget <= '0;
      linesUsed  <= '0;
    end else if (strobes.seqLoad) begin
      lineTarget <= rangeLines;
      linesUsed  <= '0;
    end else if (strobes.seqStep && linesUsed < lineTarget) begin
      linesUsed  <= linesUsed + LINE_W'(1);
    end
  end

  assign moveEn      = linesUsed < lineTarget;
  assign volleyCount = volleyCnt;

  // Assertions
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    volleyCnt <= SAT_V);
  p_hit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.cntInc && volleyCnt < SAT_V) |=> volleyCnt == $past(volleyCnt) + CNT_W'(1));
  p_sat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.cntInc && volleyCnt == SAT_V) |=> volleyCnt == SAT_V);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.cntClr |=> volleyCnt == '0);
  p_frame_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.seqLoad |=> moveEn);
  p_stay_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!moveEn && !strobes.seqLoad) |=> !moveEn);
  p_line_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lineTarget <= THR_L && linesUsed <= lineTarget);
endmodule

// File: rtl/volley_speed_gen.sv
module volley_speed_gen
  import volley_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SAT_COUNT = 12,
  parameter int MID_START = 4,
  parameter int TOP_START = 12,
  parameter int LINE_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hitStrobe,
  input  logic             speedClear,
  input  logic             frameReset,
  input  logic             lineStrobe,
  output logic             moveEn,
  output logic [CNT_W-1:0] volleyCount
);
  ctrlStrobes_t strobes;

  volley_ctrl ctrl_i (
    .hitStrobe  (hitStrobe),
    .speedClear (speedClear),
    .frameReset (frameReset),
    .lineStrobe (lineStrobe),
    .strobes    (strobes)
  );

  volley_dp #(
    .CNT_W     (CNT_W),
    .SAT_COUNT (SAT_COUNT),
    .MID_START (MID_START),
    .TOP_START (TOP_START),
    .LINE_W    (LINE_W)
  ) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .moveEn      (moveEn),
    .volleyCount (volleyCount)
  );
endmodule

// File: tb/volley_speed_gen_tb.sv
module volley_speed_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hitStrobe = 1'b0, speedClear = 1'b0, frameReset = 1'b0, lineStrobe = 1'b0;
  logic moveEn;
  logic [3:0] volleyCount;
  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  volley_speed_gen dut_i (
    .clk(clk), .rst_n(rst_n), .hitStrobe(hitStrobe), .speedClear(speedClear),
    .frameReset(frameReset), .lineStrobe(lineStrobe),
    .moveEn(moveEn), .volleyCount(volleyCount)
  );

  // {hits applied after clear, expected count, expected move lines}
  localparam bit [11:0] VEC [0:7] = '{
    {5'd0,  4'd0,  3'd1}, {5'd1,  4'd1,  3'd1}, {5'd3,  4'd3,  3'd1},
    {5'd4,  4'd4,  3'd2}, {5'd7,  4'd7,  3'd2}, {5'd11, 4'd11, 3'd2},
    {5'd12, 4'd12, 3'd3}, {5'd15, 4'd12, 3'd3}
  };

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulseHit();
    @(negedge clk) hitStrobe = 1'b1; @(negedge clk) hitStrobe = 1'b0;
  endtask
  task automatic pulseClear();
    @(negedge clk) speedClear = 1'b1; @(negedge clk) speedClear = 1'b0;
  endtask
  task automatic pulseFrame();
    @(negedge clk) frameReset = 1'b1; @(negedge clk) frameReset = 1'b0;
  endtask
  task automatic pulseLine();
    @(negedge clk) lineStrobe = 1'b1; @(negedge clk) lineStrobe = 1'b0;
  endtask

  // Count line strobes passed while moveEn is high (cap 6)
  task automatic countLines(output int n);
    n = 0;
    while (moveEn && n < 6) begin
      pulseLine();
      n++;
    end
  endtask

  initial begin
    #(200000 * 10);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int lines;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 count after reset", int'(volleyCount), 0);
    check("R10 move after reset", int'(moveEn), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 move low before first frame", int'(moveEn), 0);

    // Vector table: R1 R2 R4 R5 R6 R7
    foreach (VEC[i]) begin
      pulseClear();
      for (int h = 0; h < int'(VEC[i][11:7]); h++) pulseHit();
      check("R1/R2 count", int'(volleyCount), int'(VEC[i][6:3]));
      pulseFrame();
      check("R5 move after frame", int'(moveEn), 1);
      countLines(lines);
      check("R4/R6 move lines", lines, int'(VEC[i][2:0]));
      pulseLine(); pulseLine();
      check("R7 move stays low", int'(moveEn), 0);
    end

    // R2: hit at saturation leaves 12
    pulseHit();
    check("R2 hit at 12", int'(volleyCount), 12);

    // R3: clear and hit in same cycle -> 0
    @(negedge clk) begin speedClear = 1'b1; hitStrobe = 1'b1; end
    @(negedge clk) begin speedClear = 1'b0; hitStrobe = 1'b0; end
    check("R3 clear beats hit", int'(volleyCount), 0);

    // R8: frame reset with line strobe -> full single line remains
    pulseFrame();
    pulseLine();  // moveEn now low (count 0 -> 1 line)
    @(negedge clk) begin frameReset = 1'b1; lineStrobe = 1'b1; end
    @(negedge clk) begin frameReset = 1'b0; lineStrobe = 1'b0; end
    check("R8 move high after frame+line", int'(moveEn), 1);
    countLines(lines);
    check("R8 lines after frame+line", lines, 1);

    // R9: count 3 at frame, hit mid-frame -> still 1 line, next frame 2
    for (int h = 0; h < 3; h++) pulseHit();
    pulseFrame();
    pulseHit();
    check("R9 count after mid-frame hit", int'(volleyCount), 4);
    countLines(lines);
    check("R9 mid-frame hit deferred", lines, 1);
    pulseFrame();
    countLines(lines);
    check("R9 next frame uses new range", lines, 2);

    // R9: hit coincident with frame reset uses pre-hit count
    pulseClear();
    for (int h = 0; h < 3; h++) pulseHit();
    @(negedge clk) begin frameReset = 1'b1; hitStrobe = 1'b1; end
    @(negedge clk) begin frameReset = 1'b0; hitStrobe = 1'b0; end
    countLines(lines);
    check("R9 hit with frame deferred", lines, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule